// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the ordered list of column addresses that a synchronous DRAM burst touches. A small mode register, written through a load strobe carrying address bits, holds the burst length (1, 2, 4 or 8 words), the burst ordering (wrapping sequential or XOR interleaved) and a CAS latency field. The CAS latency field is only stored and shown to the rest of the controller. When a start pulse arrives with a column address, the block emits one column address per cycle. The requested word always comes first, and every address stays inside the aligned block of burst-length words that holds the requested column.

A memory controller uses it next to its command scheduler. It issues the start pulse together with the read or write command. It then takes the column stream, with its valid and last flags, to index data beats or to fill a cache line in critical-word-first order. Command timing and the data path belong to other blocks.

Top module: `burst_col_seq`

## Requirements
- R1: After synchronous reset, col_valid and col_last are low, cas_lat is 0, and the mode is burst length 1 with sequential ordering.
- R2: A cycle with mode_load high stores mode_bits: bits [2:0] pick the burst length (000=1, 001=2, 010=4, 011=8), bit [3] picks the ordering (0 sequential, 1 interleaved), and bits [6:4] appear on cas_lat from the next cycle. Without mode_load the stored mode does not change.
- R3: Length codes 100 to 111 give a single-word burst.
- R4: A start seen at a clock edge makes col_valid high in the following cycle, and col_out then equals start_col.
- R5: In sequential ordering, word k has block offset (s + k) mod BL, where s is the start column's offset in its block. The column bits above the block offset stay those of start_col.
- R6: In interleaved ordering, word k has block offset s XOR k, and the upper column bits stay fixed.
- R7: col_valid is high for exactly BL consecutive cycles, and col_last is high only on the BL-th. With no new start, col_valid is low in the next cycle.
- R8: A start during a burst abandons the rest of that burst, and the new burst's first word appears in the next cycle.
- R9: A burst keeps the length and ordering that were stored when its start was seen. A mode_load in the same cycle as the start, or during the burst, affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Store mode_bits into the mode register |
| mode_bits | input | 7 | Length [2:0], ordering [3], CAS latency [6:4] |
| start | input | 1 | Begin a burst at start_col |
| start_col | input | COL_W (10) | Requested column |
| col_out | output | COL_W (10) | Current column of the burst |
| col_valid | output | 1 | col_out holds a burst address |
| col_last | output | 1 | col_out is the final word of the burst |
| cas_lat | output | 3 | Stored CAS latency field |

## Verification
The bench builds the block with its defaults: a 10-bit column and a largest burst of 8 words. This keeps the 3-bit block offset small enough to sweep every start offset. Every length code and both orderings are crossed with all eight offsets under three patterns of upper column bits, and each stream is compared word by word against modular-sum and XOR arithmetic. Restarts in mid-burst, mode writes during a burst and in the same cycle as a start, and a reserved length code are driven as separate scenarios.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int MODE_W = 7;

    typedef enum logic {
        ORD_WRAP = 1'b0,
        ORD_XOR  = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic [2:0]   cas;
        burst_order_e order;
        logic [1:0]   len_log2;
    } burst_cfg_t;

    localparam burst_cfg_t CFG_RESET = '{cas: 3'd0, order: ORD_WRAP, len_log2: 2'd0};

    function automatic logic [1:0] len_code_to_log2(input logic [2:0] code);
        logic [1:0] r;
        case (code)
            3'b001:  r = 2'd1;
            3'b010:  r = 2'd2;
            3'b011:  r = 2'd3;
            default: r = 2'd0;
        endcase
        return r;
    endfunction

    function automatic burst_cfg_t decode_mode(input logic [MODE_W-1:0] bits);
        burst_cfg_t c;
        c.len_log2 = len_code_to_log2(bits[2:0]);
        c.order    = burst_order_e'(bits[3]);
        c.cas      = bits[6:4];
        return c;
    endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] bits,
    output burst_cfg_t        cfg
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= CFG_RESET;
        else if (load)
            cfg <= decode_mode(bits);
    end

    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg));

endmodule

// File: rtl/bcs_order_calc.sv
module bcs_order_calc
    import bcs_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int CNT_W = 3
) (
    input  logic [COL_W-1:0] base,
    input  logic [CNT_W-1:0] step,
    input  logic [1:0]       len_log2,
    input  burst_order_e     order,
    output logic [COL_W-1:0] col
);

    logic [CNT_W-1:0] wrap_sum;
    assign wrap_sum = base[CNT_W-1:0] + step;

    for (genvar i = 0; i < CNT_W; i++) begin : g_off
        logic in_block;
        assign in_block = (32'(len_log2) > i);
        assign col[i] = !in_block ? base[i] :
                        (order == ORD_XOR) ? (base[i] ^ step[i]) : wrap_sum[i];
    end

    assign col[COL_W-1:CNT_W] = base[COL_W-1:CNT_W];

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             col_last
);

    logic             busy;
    logic [COL_W-1:0] base;
    logic [CNT_W-1:0] step;
    logic [1:0]       len_log2;
    burst_order_e     order;
    logic [CNT_W-1:0] last_step;

    always_comb last_step = CNT_W'((32'd1 << len_log2) - 32'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            base     <= '0;
            step     <= '0;
            len_log2 <= 2'd0;
            order    <= ORD_WRAP;
        end else if (start) begin
            busy     <= 1'b1;
            base     <= start_col;
            step     <= '0;
            len_log2 <= cfg.len_log2;
            order    <= cfg.order;
        end else if (busy) begin
            if (step == last_step)
                busy <= 1'b0;
            else
                step <= step + 1'b1;
        end
    end

    bcs_order_calc #(.COL_W(COL_W), .CNT_W(CNT_W)) u_calc (
        .base     (base),
        .step     (step),
        .len_log2 (len_log2),
        .order    (order),
        .col      (col_out)
    );

    assign col_valid = busy;
    assign col_last  = busy && (step == last_step);

    assert_first_word_R4: assert property (@(posedge clk) disable iff (rst)
        start |=> (col_valid && col_out == $past(start_col)));

    assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

    assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        (col_last && !start) |=> !col_valid);

    assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !start) |=>
            (!col_valid || col_out[COL_W-1:CNT_W] == $past(col_out[COL_W-1:CNT_W])));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int MAX_BL = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_load,
    input  logic [6:0]       mode_bits,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             col_last,
    output logic [2:0]       cas_lat
);

    localparam int CNT_W = $clog2(MAX_BL);

    burst_cfg_t cfg;

    bcs_mode_reg u_mode (
        .clk  (clk),
        .rst  (rst),
        .load (mode_load),
        .bits (mode_bits),
        .cfg  (cfg)
    );

    bcs_addr_gen #(.COL_W(COL_W), .CNT_W(CNT_W)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_col (start_col),
        .cfg       (cfg),
        .col_out   (col_out),
        .col_valid (col_valid),
        .col_last  (col_last)
    );

    assign cas_lat = cfg.cas;

endmodule

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_load = 1'b0;
    logic [6:0]       mode_bits = '0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [COL_W-1:0] col_out;
    logic             col_valid;
    logic             col_last;
    logic [2:0]       cas_lat;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq uut (
        .clk(clk), .rst(rst), .mode_load(mode_load), .mode_bits(mode_bits),
        .start(start), .start_col(start_col), .col_out(col_out),
        .col_valid(col_valid), .col_last(col_last), .cas_lat(cas_lat)
    );

    function automatic int exp_col(input int col, input int bl, input bit ilv, input int k);
        int off = col % bl;
        int o = ilv ? (off ^ k) : ((off + k) % bl);
        return col - off + o;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic load_mode(input logic [6:0] b);
        @(negedge clk); mode_load = 1'b1; mode_bits = b;
        @(negedge clk); mode_load = 1'b0;
    endtask

    task automatic check_word(input string req, input int col, input int bl, input bit ilv, input int k);
        int e = exp_col(col, bl, ilv, k);
        check(col_valid && int'(col_out) == e && col_last == (k == bl - 1),
              req, int'(col_out), e);
    endtask

    // start pulse; returns at the negedge where word 0 is visible
    task automatic kick(input int col);
        @(negedge clk); start = 1'b1; start_col = COL_W'(col);
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_burst(input string req, input int col, input int bl, input bit ilv);
        kick(col);
        for (int k = 0; k < bl; k++) begin
            if (k > 0) @(negedge clk);
            check_word(req, col, bl, ilv, k);
        end
        @(negedge clk);
        check(!col_valid, "R7 idle", int'(col_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int hi [3] = '{0, 42, 127};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(!col_valid && !col_last, "R1 flags", int'(col_valid), 0);
        check(cas_lat == 3'd0, "R1 cas", int'(cas_lat), 0);
        run_burst("R1 default length", 13, 1, 1'b0);

        // R2 R5 R6 R7 sweep
        for (int code = 0; code < 4; code++) begin
            for (int ilv = 0; ilv < 2; ilv++) begin
                load_mode(7'((code) | (ilv << 3) | (((code + ilv) & 7) << 4)));
                check(int'(cas_lat) == ((code + ilv) & 7), "R2 cas", int'(cas_lat), (code + ilv) & 7);
                for (int h = 0; h < 3; h++)
                    for (int off = 0; off < 8; off++)
                        run_burst(ilv ? "R6 interleave" : "R5 sequential",
                                  hi[h] * 8 + off, 1 << code, ilv[0]);
            end
        end

        // R3 reserved length codes
        load_mode(7'b0001101);
        run_burst("R3 reserved code", 22, 1, 1'b1);
        load_mode(7'b0000111);
        run_burst("R3 reserved code", 23, 1, 1'b0);

        // R8 restart mid-burst
        load_mode(7'b0000011);
        kick(5);
        check_word("R8 first burst", 5, 8, 1'b0, 0);
        @(negedge clk); check_word("R8 first burst", 5, 8, 1'b0, 1);
        start = 1'b1; start_col = COL_W'(300);
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            check_word("R8 restart", 300, 8, 1'b0, k);
        end
        @(negedge clk);
        check(!col_valid, "R8 idle", int'(col_valid), 0);

        // R9 mode write during a burst
        kick(5);
        check_word("R9 mid-burst", 5, 8, 1'b0, 0);
        mode_load = 1'b1; mode_bits = 7'b0001001;
        @(negedge clk); mode_load = 1'b0;
        for (int k = 1; k < 8; k++) begin
            if (k > 1) @(negedge clk);
            check_word("R9 mid-burst", 5, 8, 1'b0, k);
        end
        @(negedge clk);
        check(!col_valid, "R9 idle", int'(col_valid), 0);
        // R9 same-cycle load and start: old mode (BL2 interleaved) applies
        @(negedge clk);
        start = 1'b1; start_col = COL_W'(77);
        mode_load = 1'b1; mode_bits = 7'b0001010;
        @(negedge clk); start = 1'b0; mode_load = 1'b0;
        check_word("R9 same cycle", 77, 2, 1'b1, 0);
        @(negedge clk); check_word("R9 same cycle", 77, 2, 1'b1, 1);
        @(negedge clk);
        check(!col_valid, "R9 idle", int'(col_valid), 0);
        run_burst("R9 new mode", 77, 4, 1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule